// File: doc/BRIEF.md
# Snoop Push and Data-Tenure Arbiter

This block sits between the data cache and a split-transaction processor bus whose address and data phases are arbitrated on their own. It watches snoops from other masters. When a snoop hits a modified line, the block answers with a one-cycle retry and, if it can, queues a write-back of that line so the other master finds current data in memory when it tries again. A snoop that targets the line of this processor's own outstanding read is retried without a write-back. The same holds for a dirty-hit snoop that arrives while a write-back is already queued. Each retry lasts until the blocking condition clears.

A write-back may be queued after the address phase of a read has completed but before its data phase. In that case the write-back is high priority and is enveloped inside the read. Each qualified data-bus grant is steered to either the pending load or the pending write-back. By default the grant goes to the load. A write-only qualifier sampled with the grant hands that data phase to the write-back instead. The load stays pending and takes a later grant. Each data phase is a line-sized burst of `LINE_BYTES/BEAT_BYTES` beats.

Top module: `snoop_push_arb`

## Requirements
- R1: When a snoop (`snp_valid_i`) hits a modified line (`snp_hit_i` and `snp_dirty_i` both 1), no write-back is queued and the line does not match the pending load, the following conditions hold in the cycle after the snoop: `retry_o` is 1, `push_req_o` rises, and `push_addr_o` holds the snoop address with its low log2(`LINE_BYTES`) bits cleared. `retry_o` returns to 0 in the next cycle unless another dirty-hit snoop arrives.
- R2: A snoop that misses, or that hits a clean line, never raises `retry_o` and never queues a write-back.
- R3: `push_hipri_o` is 1 with `push_req_o` when the write-back was accepted while a load was pending (enveloped), and is 0 otherwise.
- R4: A dirty-hit snoop whose line address equals the pending load's line is retried and queues no write-back. This applies to every such snoop until the load's data phase ends. After that, the same line is accepted normally.
- R5: A dirty-hit snoop that arrives while a write-back is queued is retried. It leaves `push_req_o` and `push_addr_o` unchanged.
- R6: A grant is qualified only when `dgrant_i` is 1, `dbusy_i` is 0 and no data phase is in progress. All other grants are ignored.
- R7: A qualified grant with `wo_i` at 0 while a load is pending starts a load data phase. `dten_load_o` is 1 from the next cycle.
- R8: A qualified grant with `wo_i` at 1 while a write-back is queued starts a write-back data phase. `dten_push_o` is 1 from the next cycle, even if a load is pending.
- R9: A qualified grant with no load pending and a write-back queued starts a write-back data phase, whatever the value of `wo_i`.
- R10: A data phase ends after `BEATS` (default 4) cycles with `beat_ack_i` at 1. In the cycle after the last acknowledged beat, the select output drops. In that same cycle, `push_req_o` (write-back phase) or `load_pend_o` (load phase) clears.
- R11: After an enveloped write-back finishes, the load is still pending and takes the next qualified grant that has `wo_i` at 0.
- R12: While `rst_ni` is 0, every output is 0.
- R13: `load_pend_o` is 1 in the cycle after `rd_start_i`, and the line of `rd_addr_i` becomes the pending load's line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snp_valid_i | input | 1 | Snoop from another master this cycle |
| snp_addr_i | input | AW | Snooped byte address |
| snp_hit_i | input | 1 | Snooped line is present in the cache |
| snp_dirty_i | input | 1 | Snooped line is modified |
| rd_start_i | input | 1 | Address phase of this processor's read has completed |
| rd_addr_i | input | AW | Byte address of that read |
| dgrant_i | input | 1 | Data bus grant |
| dbusy_i | input | 1 | Data bus is busy with another phase |
| wo_i | input | 1 | Write-only qualifier for the grant |
| beat_ack_i | input | 1 | Data beat acknowledge |
| retry_o | output | 1 | Snoop retry, one cycle after the snoop |
| push_req_o | output | 1 | Write-back queued and not yet finished |
| push_hipri_o | output | 1 | Queued write-back is enveloped in a read |
| push_addr_o | output | AW | Line-aligned write-back address |
| load_pend_o | output | 1 | Load data phase still owed |
| dten_load_o | output | 1 | Current data phase belongs to the load |
| dten_push_o | output | 1 | Current data phase belongs to the write-back |

## Verification
The assertions assume that `rd_start_i` pulses only while no load is pending. They also assume that `beat_ack_i` is meaningful only during a data phase this block owns. The stimulus respects both: it starts each read only after the previous one's data phase has completed, and it raises acknowledges only while a select output is high. Grants are offered while the bus is busy, while a data phase is in progress and while nothing is pending, so that the qualification rule is exercised. The stimulus does not assume any spacing between snoops.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [1:0] {
    TEN_NONE = 2'd0,
    TEN_LOAD = 2'd1,
    TEN_PUSH = 2'd2
  } ten_e;
endpackage

// File: rtl/sps_rd_track.sv
module sps_rd_track #(
  parameter int LW = 27
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_start_i,
  input  logic [LW-1:0] rd_line_i,
  input  logic          load_done_i,
  output logic          rd_pend_o,
  output logic [LW-1:0] rd_line_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_o <= 1'b0;
      rd_line_o <= '0;
    end else begin
      rd_pend_o <= (rd_pend_o & ~load_done_i) | rd_start_i;
      if (rd_start_i) rd_line_o <= rd_line_i;
    end
  end

  // R13
  rd_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start_i |=> rd_pend_o);
endmodule

// File: rtl/sps_snoop_resp.sv
module sps_snoop_resp #(
  parameter int LW = 27
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          snp_valid_i,
  input  logic [LW-1:0] snp_line_i,
  input  logic          snp_hit_i,
  input  logic          snp_dirty_i,
  input  logic          rd_pend_i,
  input  logic [LW-1:0] rd_line_i,
  input  logic          push_done_i,
  output logic          retry_o,
  output logic          push_pend_o,
  output logic          push_hipri_o,
  output logic [LW-1:0] push_line_o
);
  logic dirty_hit, rd_match, accept;

  assign dirty_hit = snp_valid_i & snp_hit_i & snp_dirty_i;
  assign rd_match  = rd_pend_i & (snp_line_i == rd_line_i);
  assign accept    = dirty_hit & ~rd_match & ~push_pend_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      retry_o      <= 1'b0;
      push_pend_o  <= 1'b0;
      push_hipri_o <= 1'b0;
      push_line_o  <= '0;
    end else begin
      retry_o <= dirty_hit;
      if (push_done_i) begin
        push_pend_o  <= 1'b0;
        push_hipri_o <= 1'b0;
      end
      if (accept) begin
        push_pend_o  <= 1'b1;
        push_hipri_o <= rd_pend_i;  // enveloped inside an open read
        push_line_o  <= snp_line_i;
      end
    end
  end

  // R2
  no_clean_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> $past(snp_valid_i && snp_hit_i && snp_dirty_i));

  // R4
  match_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_hit_i && snp_dirty_i && rd_pend_i &&
     snp_line_i == rd_line_i && !push_pend_o) |=> !push_pend_o);

  // R5
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_pend_o && !push_done_i) |=> (push_pend_o && $stable(push_line_o)));
endmodule

// File: rtl/sps_dten_steer.sv
module sps_dten_steer
  import sps_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dgrant_i,
  input  logic dbusy_i,
  input  logic wo_i,
  input  logic beat_ack_i,
  input  logic rd_pend_i,
  input  logic push_pend_i,
  output logic dten_load_o,
  output logic dten_push_o,
  output logic load_done_o,
  output logic push_done_o
);
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

  ten_e          ten_q, pick;
  logic [BW-1:0] cnt_q;
  logic          qual, last;

  assign qual = dgrant_i & ~dbusy_i & (ten_q == TEN_NONE);
  assign last = (ten_q != TEN_NONE) & beat_ack_i & (cnt_q == LAST_BEAT);

  // write-only qualifier redirects the tenure; otherwise the load wins
  always_comb begin
    if (wo_i && push_pend_i)  pick = TEN_PUSH;
    else if (rd_pend_i)       pick = TEN_LOAD;
    else if (push_pend_i)     pick = TEN_PUSH;
    else                      pick = TEN_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ten_q <= TEN_NONE;
      cnt_q <= '0;
    end else if (ten_q == TEN_NONE) begin
      cnt_q <= '0;
      if (qual) ten_q <= pick;
    end else if (beat_ack_i) begin
      if (last) begin
        ten_q <= TEN_NONE;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign dten_load_o = (ten_q == TEN_LOAD);
  assign dten_push_o = (ten_q == TEN_PUSH);
  assign load_done_o = last & (ten_q == TEN_LOAD);
  assign push_done_o = last & (ten_q == TEN_PUSH);

  // R6
  busy_grant_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dgrant_i && dbusy_i && !dten_load_o && !dten_push_o) |=> (!dten_load_o && !dten_push_o));

  // R8
  wo_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dgrant_i && !dbusy_i && !dten_load_o && !dten_push_o && wo_i && push_pend_i) |=> dten_push_o);

  // R10
  tenure_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dten_push_o) || $fell(dten_load_o)) |-> $past(beat_ack_i));
endmodule

// File: rtl/snoop_push_arb.sv
module snoop_push_arb #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int BEAT_BYTES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          snp_valid_i,
  input  logic [AW-1:0] snp_addr_i,
  input  logic          snp_hit_i,
  input  logic          snp_dirty_i,
  input  logic          rd_start_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          dgrant_i,
  input  logic          dbusy_i,
  input  logic          wo_i,
  input  logic          beat_ack_i,
  output logic          retry_o,
  output logic          push_req_o,
  output logic          push_hipri_o,
  output logic [AW-1:0] push_addr_o,
  output logic          load_pend_o,
  output logic          dten_load_o,
  output logic          dten_push_o
);
  localparam int OFF   = $clog2(LINE_BYTES);
  localparam int LW    = AW - OFF;
  localparam int BEATS = LINE_BYTES / BEAT_BYTES;

  logic          rd_pend, push_pend, load_done, push_done;
  logic [LW-1:0] rd_line, push_line;

  sps_rd_track #(.LW(LW)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_start_i  (rd_start_i),
    .rd_line_i   (rd_addr_i[AW-1:OFF]),
    .load_done_i (load_done),
    .rd_pend_o   (rd_pend),
    .rd_line_o   (rd_line)
  );

  sps_snoop_resp #(.LW(LW)) u_snp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .snp_valid_i  (snp_valid_i),
    .snp_line_i   (snp_addr_i[AW-1:OFF]),
    .snp_hit_i    (snp_hit_i),
    .snp_dirty_i  (snp_dirty_i),
    .rd_pend_i    (rd_pend),
    .rd_line_i    (rd_line),
    .push_done_i  (push_done),
    .retry_o      (retry_o),
    .push_pend_o  (push_pend),
    .push_hipri_o (push_hipri_o),
    .push_line_o  (push_line)
  );

  sps_dten_steer #(.BEATS(BEATS)) u_ten (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dgrant_i    (dgrant_i),
    .dbusy_i     (dbusy_i),
    .wo_i        (wo_i),
    .beat_ack_i  (beat_ack_i),
    .rd_pend_i   (rd_pend),
    .push_pend_i (push_pend),
    .dten_load_o (dten_load_o),
    .dten_push_o (dten_push_o),
    .load_done_o (load_done),
    .push_done_o (push_done)
  );

  assign push_req_o  = push_pend;
  assign load_pend_o = rd_pend;
  assign push_addr_o = {push_line, {OFF{1'b0}}};
endmodule

// File: tb/snoop_push_arb_bench.sv
`timescale 1ns/1ps
module snoop_push_arb_bench;
  localparam int AW = 32;
  localparam int NV = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          snp_valid_i = 1'b0, snp_hit_i = 1'b0, snp_dirty_i = 1'b0;
  logic [AW-1:0] snp_addr_i = '0;
  logic          rd_start_i = 1'b0;
  logic [AW-1:0] rd_addr_i = 32'h1000_0040;
  logic          dgrant_i = 1'b0, dbusy_i = 1'b0, wo_i = 1'b0, beat_ack_i = 1'b0;
  logic          retry_o, push_req_o, push_hipri_o, load_pend_o, dten_load_o, dten_push_o;
  logic [AW-1:0] push_addr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  snoop_push_arb u_snoop_push_arb (.*);

  function automatic logic [AW-1:0] addr_of(input logic [1:0] c);
    case (c)
      2'd0:    return 32'h1000_0040;  // line of the read
      2'd1:    return 32'h2000_0080;
      2'd2:    return 32'h1000_0044;  // same line as code 0
      default: return 32'h3000_005C;
    endcase
  endfunction

  // {req, sv, addr, hit, dirty, rd_start, grant, busy, wo, ack, exp: retry preq hipri lpend dl dp}
  localparam logic [19:0] VEC [NV] = '{
    {4'd13, 10'b0_00_0_0_1_0_0_0_0, 6'b000100},  // R13 read opened
    {4'd2,  10'b1_01_0_0_0_0_0_0_0, 6'b000100},  // R2 miss
    {4'd2,  10'b1_01_1_0_0_0_0_0_0, 6'b000100},  // R2 clean hit
    {4'd4,  10'b1_10_1_1_0_0_0_0_0, 6'b100100},  // R4 same line as read
    {4'd3,  10'b1_01_1_1_0_0_0_0_0, 6'b111100},  // R3 enveloped push
    {4'd5,  10'b1_01_1_1_0_0_0_0_0, 6'b111100},  // R5 second dirty hit
    {4'd6,  10'b0_00_0_0_0_1_1_1_0, 6'b011100},  // R6 busy grant
    {4'd8,  10'b0_00_0_0_0_1_0_1_0, 6'b011101},  // R8 wo grant
    {4'd4,  10'b1_00_1_1_0_0_0_0_0, 6'b111101},  // R4 repeat retry
    {4'd10, 10'b0_00_0_0_0_0_0_0_1, 6'b011101},
    {4'd6,  10'b0_00_0_0_0_1_0_0_1, 6'b011101},  // R6 grant in tenure
    {4'd10, 10'b0_00_0_0_0_0_0_0_1, 6'b011101},
    {4'd10, 10'b0_00_0_0_0_0_0_0_1, 6'b000100},  // R10 push done
    {4'd11, 10'b0_00_0_0_0_1_0_0_0, 6'b000110},  // R11 load next
    {4'd10, 10'b0_00_0_0_0_0_0_0_1, 6'b000110},
    {4'd10, 10'b0_00_0_0_0_0_0_0_1, 6'b000110},
    {4'd10, 10'b0_00_0_0_0_0_0_0_1, 6'b000110},
    {4'd10, 10'b0_00_0_0_0_0_0_0_1, 6'b000000},  // R10 load done
    {4'd1,  10'b1_00_1_1_0_0_0_0_0, 6'b110000},  // R1 normal push, R4 released
    {4'd13, 10'b0_00_0_0_1_0_0_0_0, 6'b010100},
    {4'd7,  10'b0_00_0_0_0_1_0_0_0, 6'b010110},  // R7 load wins
    {4'd5,  10'b1_01_1_1_0_0_0_0_0, 6'b110110},  // R5
    {4'd10, 10'b0_00_0_0_0_0_0_0_1, 6'b010110},
    {4'd10, 10'b0_00_0_0_0_0_0_0_1, 6'b010110},
    {4'd10, 10'b0_00_0_0_0_0_0_0_1, 6'b010110},
    {4'd10, 10'b0_00_0_0_0_0_0_0_1, 6'b010000},
    {4'd9,  10'b0_00_0_0_0_1_0_0_0, 6'b010001},  // R9 push, no load
    {4'd10, 10'b0_00_0_0_0_0_0_0_1, 6'b010001},
    {4'd10, 10'b0_00_0_0_0_0_0_0_1, 6'b010001},
    {4'd10, 10'b0_00_0_0_0_0_0_0_1, 6'b010001},
    {4'd10, 10'b0_00_0_0_0_0_0_0_1, 6'b000000},
    {4'd6,  10'b0_00_0_0_0_1_0_0_0, 6'b000000}   // R6 nothing pending
  };

  function automatic logic [5:0] outs();
    return {retry_o, push_req_o, push_hipri_o, load_pend_o, dten_load_o, dten_push_o};
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    snp_valid_i = 0; snp_hit_i = 0; snp_dirty_i = 0; rd_start_i = 0;
    dgrant_i = 0; dbusy_i = 0; wo_i = 0; beat_ack_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R12 reset", {26'd0, outs()}, '0);
    check("R12 reset addr", push_addr_o, '0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {snp_valid_i, snp_addr_i, snp_hit_i, snp_dirty_i, rd_start_i,
       dgrant_i, dbusy_i, wo_i, beat_ack_i} =
        {VEC[i][15], addr_of(VEC[i][14:13]), VEC[i][12:6]};
      @(negedge clk_i);
      n_chk++;
      if (outs() !== VEC[i][5:0]) begin
        n_bad++;
        $display("FAIL R%0d vector %0d: got %b expected %b", VEC[i][19:16], i, outs(), VEC[i][5:0]);
      end
    end

    // R1 alignment and pulse; R13 with snoop in the same cycle
    snp_valid_i = 1; snp_addr_i = addr_of(2'd3); snp_hit_i = 1; snp_dirty_i = 1;
    rd_start_i = 1; rd_addr_i = 32'h4000_0000;
    @(negedge clk_i);
    check("R1 push address", push_addr_o, 32'h3000_0040);
    check("R1 retry", {31'd0, retry_o}, 1);
    check("R3 no envelope", {31'd0, push_hipri_o}, 0);
    check("R13 load pending", {31'd0, load_pend_o}, 1);
    idle();
    @(negedge clk_i);
    check("R1 retry pulse ends", {31'd0, retry_o}, 0);
    check("R1 push held", {31'd0, push_req_o}, 1);

    // R12 asynchronous reset
    rst_ni = 1'b0;
    #1;
    check("R12 async reset", {26'd0, outs()}, '0);
    check("R12 async reset addr", push_addr_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R12 after release", {26'd0, outs()}, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule